// File: doc/BRIEF.md
# Shared-Memory Accumulator Processor

A minimal accumulator processor in which instructions and operands live in the same 16-cell, 8-bit memory. That memory has one synchronous port for both reads and writes. Each instruction word holds an operation code in its upper nibble and an absolute cell number in its lower nibble. Because one port serves both kinds of access, every instruction first reads its own word, latching the operation code and the operand cell into separate registers. It then steers the port to the operand cell for the data access. The processor provides load, add, store and an unconditional jump. Every other operation code does nothing.

A host fills memory through a loader port. While the loader is active, it owns the memory port and the processor is frozen: the program counter and accumulator keep their values. Any instruction in progress is abandoned and is fetched again afterwards. Releasing the loader starts or resumes execution at the current program counter.

The controller has five states:
- FETCH: the port reads the cell at the program counter.
- DECODE: the instruction word is latched. A jump or a no-operation finishes here.
- OPERAND: the port is steered to the operand cell.
- ACCUM: the read cell is loaded into, or added to, the accumulator.
- WRITE: the accumulator is stored into the operand cell.

The transitions are:
- FETCH to DECODE.
- DECODE to OPERAND for load, add and store.
- DECODE back to FETCH for a jump or a no-operation.
- OPERAND to WRITE for a store.
- OPERAND to ACCUM otherwise.
- ACCUM or WRITE back to FETCH.
- Any state to FETCH whenever the loader is active.

Top module: `nibble_acc_cpu`

## Requirements
- R1: While reset is asserted, and right after it is released, the program counter is 0, the accumulator is 0 and `running` is 0. The controller starts in FETCH.
- R2: An instruction word carries its operation code in bits 7:4 and its operand cell in bits 3:0. Operation code 3 (load) copies the operand cell into the accumulator. Load takes four cycles and then adds one to the program counter.
- R3: Operation code 2 (add) adds the operand cell to the accumulator, modulo 256. Add takes four cycles and then adds one to the program counter.
- R4: Operation code 4 (store) writes the accumulator into the operand cell and leaves the accumulator unchanged. Store takes four cycles and then adds one to the program counter.
- R5: Operation code 8 (jump) loads bits 3:0 of the word into the program counter. Jump takes two cycles and leaves the accumulator unchanged.
- R6: Every other operation code is a no-operation. It takes two cycles, adds one to the program counter and leaves the accumulator unchanged.
- R7: The program counter wraps from 15 to 0.
- R8: On each rising edge where `load_en` is 1, `load_data` is written to cell `load_addr`. On such an edge the program counter and accumulator are held, the instruction in progress is abandoned (a store in its WRITE cycle included), and the controller returns to FETCH. Execution resumes at the held program counter.
- R9: `running` is a registered copy of the inverse of `load_en`, taken at each rising edge after reset.
- R10: A store drives its write strobe only in the cycle after the operand cell was steered onto the memory port. The address is unchanged across those two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Loader owns the memory port and freezes the processor |
| load_addr | input | 4 | Cell written by the loader |
| load_data | input | 8 | Value written by the loader |
| acc | output | 8 | Accumulator |
| pc | output | 4 | Program counter |
| running | output | 1 | 1 while the processor is executing |

## Verification
The loader and a store both want to write through the one memory port, and they can meet in the same cycle. The bench provokes this by asserting the loader exactly on the edge that ends a store's WRITE state, writing a different value to the store's target cell. The outcome is judged by letting execution resume and later loading that cell back into the accumulator. Two things must hold: the program counter did not advance at the collision, and the re-executed store finally leaves the accumulator's value in the cell. A second collision freezes an add between its DECODE and OPERAND states. That add must then produce the same sum as an undisturbed run, with no double addition.

// File: rtl/nacpu_pkg.sv
package nacpu_pkg;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_ADD   = 4'h2;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h3;
    localparam logic [OPC_W-1:0] OPC_STORE = 4'h4;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 4'h8;

    typedef enum logic [2:0] {
        ST_FETCH   = 3'd0,
        ST_DECODE  = 3'd1,
        ST_OPERAND = 3'd2,
        ST_ACCUM   = 3'd3,
        ST_WRITE   = 3'd4
    } nacpu_state_e;

endpackage

// File: rtl/nacpu_ram.sv
module nacpu_ram #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // One port: the read returns the value held before a same-edge write.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
        rdata <= cells[addr];
    end

endmodule

// File: rtl/nacpu_ctrl.sv
module nacpu_ctrl
    import nacpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [OPC_W-1:0] word_opc,
    input  logic [OPC_W-1:0] held_opc,
    output nacpu_state_e     state,
    output logic             ir_load,
    output logic             sel_operand,
    output logic             mem_we,
    output logic             acc_load,
    output logic             acc_add,
    output logic             pc_inc,
    output logic             pc_jump
);
    nacpu_state_e nxt;
    logic         word_is_mem;

    assign word_is_mem = (word_opc == OPC_LOAD) || (word_opc == OPC_ADD) ||
                         (word_opc == OPC_STORE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FETCH;
        end else begin
            state <= nxt;
        end
    end

    // Next state
    always_comb begin
        nxt = ST_FETCH;
        if (!hold) begin
            unique case (state)
                ST_FETCH:   nxt = ST_DECODE;
                ST_DECODE:  nxt = word_is_mem ? ST_OPERAND : ST_FETCH;
                ST_OPERAND: nxt = (held_opc == OPC_STORE) ? ST_WRITE : ST_ACCUM;
                ST_ACCUM:   nxt = ST_FETCH;
                ST_WRITE:   nxt = ST_FETCH;
                default:    nxt = ST_FETCH;
            endcase
        end
    end

    // Outputs
    always_comb begin
        ir_load     = 1'b0;
        sel_operand = 1'b0;
        mem_we      = 1'b0;
        acc_load    = 1'b0;
        acc_add     = 1'b0;
        pc_inc      = 1'b0;
        pc_jump     = 1'b0;
        if (!hold) begin
            unique case (state)
                ST_FETCH: ;
                ST_DECODE: begin
                    ir_load = 1'b1;
                    pc_jump = (word_opc == OPC_JUMP);
                    pc_inc  = !word_is_mem && (word_opc != OPC_JUMP);
                end
                ST_OPERAND: sel_operand = 1'b1;
                ST_ACCUM: begin
                    acc_load = (held_opc == OPC_LOAD);
                    acc_add  = (held_opc == OPC_ADD);
                    pc_inc   = 1'b1;
                end
                ST_WRITE: begin
                    sel_operand = 1'b1;
                    mem_we      = 1'b1;
                    pc_inc      = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R10: the write state is entered only from the operand state
    p_write_after_operand_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WRITE |-> $past(state) == ST_OPERAND);

    // R8: an active loader always sends the controller back to fetch
    p_hold_to_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> state == ST_FETCH);

endmodule

// File: rtl/nibble_acc_cpu.sv
module nibble_acc_cpu
    import nacpu_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    output logic [DATA_W-1:0] acc,
    output logic [ADDR_W-1:0] pc,
    output logic              running
);
    localparam int OPC_LSB = DATA_W - OPC_W;

    logic [DATA_W-1:0] rdata;
    logic [DATA_W-1:0] ram_wdata;
    logic [ADDR_W-1:0] ram_addr;
    logic              ram_we;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] opr_q;
    logic [OPC_W-1:0]  opc_q;
    logic [DATA_W-1:0] acc_q;
    logic              run_q;

    nacpu_state_e state;
    logic ir_load, sel_operand, mem_we, acc_load, acc_add, pc_inc, pc_jump;

    nacpu_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold        (load_en),
        .word_opc    (rdata[DATA_W-1:OPC_LSB]),
        .held_opc    (opc_q),
        .state       (state),
        .ir_load     (ir_load),
        .sel_operand (sel_operand),
        .mem_we      (mem_we),
        .acc_load    (acc_load),
        .acc_add     (acc_add),
        .pc_inc      (pc_inc),
        .pc_jump     (pc_jump)
    );

    // Port steering: loader, then operand cell, then program counter
    always_comb begin
        if (load_en) begin
            ram_addr  = load_addr;
            ram_wdata = load_data;
            ram_we    = 1'b1;
        end else begin
            ram_addr  = sel_operand ? opr_q : pc_q;
            ram_wdata = acc_q;
            ram_we    = mem_we;
        end
    end

    nacpu_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            acc_q <= '0;
            opc_q <= '0;
            opr_q <= '0;
            run_q <= 1'b0;
        end else begin
            run_q <= !load_en;
            if (ir_load) begin
                opc_q <= rdata[DATA_W-1:OPC_LSB];
                opr_q <= rdata[ADDR_W-1:0];
            end
            if (pc_jump) begin
                pc_q <= rdata[ADDR_W-1:0];
            end else if (pc_inc) begin
                pc_q <= pc_q + 1'b1;
            end
            if (acc_load) begin
                acc_q <= rdata;
            end else if (acc_add) begin
                acc_q <= acc_q + rdata;
            end
        end
    end

    assign acc     = acc_q;
    assign pc      = pc_q;
    assign running = run_q;

    // R8: loader edges leave the architectural state untouched
    p_loader_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> $stable(pc_q) && $stable(acc_q));

    // R10: the strobe comes one cycle after the address was set up
    p_store_setup_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !load_en) |-> $past(ram_addr) == ram_addr);

    // R3: addition wraps at the data width
    p_add_wraps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_add |=> acc_q == DATA_W'($past(acc_q) + $past(rdata)));

    // R5: jump lands on the low nibble of the word just read
    p_jump_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_jump |=> pc_q == $past(rdata[ADDR_W-1:0]));

    // R9: running follows the loader with one register
    p_running_r9: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> !$past(load_en));

endmodule

// File: tb/nibble_acc_cpu_test.sv
`timescale 1ns/1ps
module nibble_acc_cpu_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_en = 1'b0;
    logic [3:0] load_addr = '0;
    logic [7:0] load_data = '0;
    logic [7:0] acc;
    logic [3:0] pc;
    logic       running;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nibble_acc_cpu uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_addr (load_addr),
        .load_data (load_data),
        .acc       (acc),
        .pc        (pc),
        .running   (running)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic steps(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        load_en = 1'b0;
        rst_n   = 1'b0;
        steps(2);
        rst_n = 1'b1;
    endtask

    task automatic poke(input logic [3:0] a, input logic [7:0] d);
        load_en   = 1'b1;
        load_addr = a;
        load_data = d;
        steps(1);
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 16; i++) poke(4'(i), 8'h00);
    endtask

    task automatic load_sum_prog();
        clear_mem();
        poke(4'h0, 8'h38); poke(4'h1, 8'h29); poke(4'h2, 8'h2a);
        poke(4'h3, 8'h4b); poke(4'h4, 8'h3c); poke(4'h5, 8'h3b);
        poke(4'h6, 8'h86);
        poke(4'h8, 8'h05); poke(4'h9, 8'h07); poke(4'ha, 8'h0c);
        poke(4'hc, 8'h77);
        load_en = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        #1;
        chk("R1 pc in reset", pc, 0);
        chk("R1 acc in reset", acc, 0);
        chk("R1 running in reset", running, 0);
        do_reset();
        chk("R1 pc after reset", pc, 0);
        chk("R1 acc after reset", acc, 0);
    endtask

    task automatic t_sum_prog();
        do_reset();
        load_sum_prog();
        steps(4);
        chk("R9 running after release", running, 1);
        chk("R2 load acc", acc, 8'h05);  chk("R2 load pc", pc, 1);
        steps(4);
        chk("R3 add acc", acc, 8'h0c);   chk("R3 add pc", pc, 2);
        steps(4);
        chk("R3 second add acc", acc, 8'h18);
        steps(3);
        chk("R4 store pc not yet", pc, 3);
        steps(1);
        chk("R4 store pc", pc, 4);       chk("R4 store acc kept", acc, 8'h18);
        steps(4);
        chk("R2 load other cell", acc, 8'h77);
        steps(4);
        chk("R4 stored value read back", acc, 8'h18);
        chk("R5 pc at jump", pc, 6);
        steps(6);
        chk("R5 jump to self pc", pc, 6);
        chk("R5 jump keeps acc", acc, 8'h18);
    endtask

    task automatic t_wrap_nop();
        do_reset();
        clear_mem();
        poke(4'h0, 8'h3d); poke(4'h1, 8'h2e); poke(4'h2, 8'h8f);
        poke(4'hd, 8'hf0); poke(4'he, 8'h20); poke(4'hf, 8'h70);
        load_en = 1'b0;
        steps(8);
        chk("R3 modulo 256 sum", acc, 8'h10);
        steps(1);
        chk("R5 jump not before two cycles", pc, 2);
        steps(1);
        chk("R5 jump target", pc, 4'hf);
        steps(1);
        chk("R6 nop pc mid", pc, 4'hf);
        steps(1);
        chk("R7 pc wraps to 0", pc, 0);
        chk("R6 nop keeps acc", acc, 8'h10);
        steps(4);
        chk("R7 reexec after wrap", acc, 8'hf0);
    endtask

    task automatic t_freeze_add();
        do_reset();
        load_sum_prog();
        steps(10);
        poke(4'he, 8'h55); poke(4'he, 8'h55); poke(4'he, 8'h55);
        chk("R8 pc held", pc, 2);
        chk("R8 acc held", acc, 8'h0c);
        chk("R9 running low while loading", running, 0);
        load_en = 1'b0;
        steps(4);
        chk("R8 add restarts once", acc, 8'h18);
        chk("R8 pc after restart", pc, 3);
        steps(12);
        chk("R8 program completes", acc, 8'h18);
    endtask

    task automatic t_collide_store();
        do_reset();
        load_sum_prog();
        steps(15);
        poke(4'hb, 8'h99);
        chk("R8 store aborted pc", pc, 3);
        load_en = 1'b0;
        steps(4);
        chk("R8 store reissued pc", pc, 4);
        steps(8);
        chk("R8 reissued store wins", acc, 8'h18);
        chk("R8 final pc", pc, 6);
    endtask

    initial begin
        t_reset();
        t_sum_prog();
        t_wrap_nop();
        t_freeze_add();
        t_collide_store();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule